// File: doc/BRIEF.md
# Radix-16 Recoded Systolic Matrix Multiplier

This block multiplies two small signed integer matrices on a square grid of multiply-accumulate cells. Each cycle one element per row of the left operand and one element per column of the right operand are presented in parallel. The block delays each lane internally, so the terms that belong together meet in the right cell. Every cell keeps a 24-bit signed running sum. The host clears the sums, streams the shared dimension, waits for the completion pulse and then reads the result one row at a time.

The right-hand operand of every product is converted once, at the top edge of the grid, into signed radix-16 digits. Each digit is carried as a 4-bit magnitude from 0 to 8 plus a sign. The digits then travel down their column next to the valid flag. A cell has no recoding logic. It forms the nine multiples 0x to 8x of its left operand, using adders only for 3x, 5x and 7x, and picks one multiple per digit with a multiplexer. It negates the pick with an invert and a carry-in. It weights the upper digit by 16 and adds the result into its accumulator.

Top module: `sa_r16_array`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every accumulator is zero, `done` is low and `rd_data` is zero.
- R2: Each 8-bit column operand b is split into two digits. Digit k is -8*b[4k+3] + 4*b[4k+2] + 2*b[4k+1] + b[4k] + b[4k-1], with b[-1] taken as 0, so each digit lies in -8..+8. Every product added to an accumulator equals the exact signed 16-bit product, for all operand pairs including -128 times -128 (16384).
- R3: Row lane i is `a_data[8i+7:8i]` and column lane j is `b_data[8j+7:8j]`, both two's complement. After a burst of injections, cell (i,j) holds the sum of a_i*b_j over the injections since the last clear, modulo 2^24.
- R4: A cycle contributes a term only when `a_valid` and `b_valid` are both high at that edge. With one or both flags low, no accumulator changes.
- R5: A term injected at clock edge E is added to cell (i,j) at edge E+i+j+1.
- R6: A clock edge with `clr` high sets every accumulator to zero. A term that reaches a cell at that same edge is discarded.
- R7: `done` is high for exactly one cycle. It rises at edge EL+7, where EL is the last injection of a run of consecutive injections (ROWS+COLS-1 = 7).
- R8: At each edge, `rd_data` takes the accumulators of row `rd_row` as they stood before that edge, with column j at bits [24j+23:24j].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all accumulators |
| a_valid | input | 1 | Row operands valid this cycle |
| a_data | input | 32 | One signed 8-bit element per row |
| b_valid | input | 1 | Column operands valid this cycle |
| b_data | input | 32 | One signed 8-bit element per column |
| rd_row | input | 2 | Row selected for readout |
| rd_data | output | 96 | Registered accumulators of the selected row |
| done | output | 1 | One-cycle pulse when the last burst's terms have landed |

## Verification
Two things can land at the same edge. A clear can coincide with terms still in flight along the skewed diagonals, and a readout can coincide with an accumulation. The bench raises `clr` in the middle of a burst. Some cells then lose the term that arrives exactly at the clear edge, while cells further down the diagonal keep the terms that arrive later. A time-indexed model of arrivals decides which terms survive. Because `rd_row` sweeps every cycle throughout, each readout is judged against the values held just before its edge, including edges where that row is being updated.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // One signed radix-16 digit: magnitude 0..8 plus sign
  typedef struct packed {
    logic       neg;
    logic [3:0] mag;
  } r16_digit_t;

  localparam int DIGIT_W = 5;

  // win = {b[4k+3], b[4k+2], b[4k+1], b[4k], b[4k-1]}
  function automatic r16_digit_t r16_encode(input logic [4:0] win);
    logic signed [5:0] v;
    logic signed [5:0] nv;
    r16_digit_t        d;
    v  = $signed({3'b000, win[3:1]}) + $signed({5'b00000, win[0]})
         - (win[4] ? 6'sd8 : 6'sd0);
    nv = -v;
    d.neg = v[5];
    d.mag = v[5] ? nv[3:0] : v[3:0];
    return d;
  endfunction

endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
        end else begin
          stage[0] <= din;
          for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sa_recoder.sv
module sa_recoder
  import sa_pkg::*;
#(
  parameter int DW = 8,
  localparam int NDIG = DW / 4
) (
  input  logic [DW-1:0]              op,
  output r16_digit_t [NDIG-1:0]      dig
);
  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_dig
      if (k == 0) begin : g_low
        assign dig[k] = r16_encode({op[3:0], 1'b0});
      end else begin : g_high
        assign dig[k] = r16_encode({op[4*k+3:4*k], op[4*k-1]});
      end
    end
  endgenerate
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 24,
  localparam int NDIG = DW / 4,
  localparam int MW   = DW + 4,
  localparam int PW   = 2 * DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [DW-1:0]         a_op,
  input  logic                  a_vld,
  input  r16_digit_t [NDIG-1:0] b_dig,
  input  logic                  b_vld,
  output logic [AW-1:0]         acc
);
  // Multiples of the multiplicand: only 3x, 5x, 7x need an adder
  logic signed [MW-1:0] x1, x2, x3, x4, x5, x6, x7, x8;
  assign x1 = MW'($signed(a_op));
  assign x2 = x1 <<< 1;
  assign x4 = x1 <<< 2;
  assign x8 = x1 <<< 3;
  assign x3 = x1 + x2;
  assign x5 = x1 + x4;
  assign x6 = x3 <<< 1;
  assign x7 = x8 - x1;

  logic signed [MW-1:0] pp [NDIG];

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_pp
      logic signed [MW-1:0] pick;
      always_comb begin
        case (b_dig[k].mag)
          4'd1:    pick = x1;
          4'd2:    pick = x2;
          4'd3:    pick = x3;
          4'd4:    pick = x4;
          4'd5:    pick = x5;
          4'd6:    pick = x6;
          4'd7:    pick = x7;
          4'd8:    pick = x8;
          default: pick = '0;
        endcase
        pp[k] = (pick ^ {MW{b_dig[k].neg}}) + MW'(b_dig[k].neg);
      end
    end
  endgenerate

  // Reduction: one partial product per digit, weight 16^k
  logic signed [PW-1:0] prod;
  always_comb begin
    prod = '0;
    for (int k = 0; k < NDIG; k++) begin
      prod = prod + (PW'(pp[k]) <<< (4 * k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (a_vld && b_vld) acc <= acc + AW'(prod);
  end
endmodule

// File: rtl/sa_r16_array.sv
module sa_r16_array
  import sa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 24,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 a_valid,
  input  logic [ROWS*DW-1:0]   a_data,
  input  logic                 b_valid,
  input  logic [COLS*DW-1:0]   b_data,
  input  logic [RW-1:0]        rd_row,
  output logic [COLS*AW-1:0]   rd_data,
  output logic                 done
);
  localparam int NDIG = DW / 4;
  localparam int CW   = 1 + NDIG * DIGIT_W;
  localparam int LAT  = ROWS + COLS - 1;

  logic [DW-1:0]         a_bus  [ROWS][COLS];
  logic                  av_bus [ROWS][COLS];
  r16_digit_t [NDIG-1:0] d_bus  [ROWS][COLS];
  logic                  bv_bus [ROWS][COLS];
  logic [AW-1:0]         acc_g  [ROWS][COLS];
  logic [ROWS*COLS*AW-1:0] acc_flat;

  // Row edge: register plus i cycles of skew
  generate
    for (genvar i = 0; i < ROWS; i++) begin : g_row_edge
      logic [DW:0] row_out;
      sa_delay #(.W(DW + 1), .DEPTH(i + 1)) u_skew (
        .clk (clk), .rst (rst),
        .din ({a_valid, a_data[i*DW +: DW]}),
        .dout(row_out)
      );
      assign av_bus[i][0] = row_out[DW];
      assign a_bus[i][0]  = row_out[DW-1:0];
    end

    // Column edge: shared recoder, register plus j cycles of skew
    for (genvar j = 0; j < COLS; j++) begin : g_col_edge
      r16_digit_t [NDIG-1:0] dig_c;
      logic [CW-1:0]         col_out;
      sa_recoder #(.DW(DW)) u_rc (
        .op (b_data[j*DW +: DW]),
        .dig(dig_c)
      );
      sa_delay #(.W(CW), .DEPTH(j + 1)) u_skew (
        .clk (clk), .rst (rst),
        .din ({b_valid, dig_c}),
        .dout(col_out)
      );
      assign bv_bus[0][j] = col_out[CW-1];
      assign d_bus[0][j]  = col_out[CW-2:0];
    end

    // Grid of cells with neighbour-to-neighbour pipeline stages
    for (genvar i = 0; i < ROWS; i++) begin : g_r
      for (genvar j = 0; j < COLS; j++) begin : g_c
        sa_pe #(.DW(DW), .AW(AW)) u_pe (
          .clk  (clk), .rst (rst), .clr (clr),
          .a_op (a_bus[i][j]),  .a_vld(av_bus[i][j]),
          .b_dig(d_bus[i][j]),  .b_vld(bv_bus[i][j]),
          .acc  (acc_g[i][j])
        );
        assign acc_flat[(i*COLS+j)*AW +: AW] = acc_g[i][j];

        if (j < COLS - 1) begin : g_right
          logic [DW:0] rq;
          sa_delay #(.W(DW + 1), .DEPTH(1)) u_hop (
            .clk(clk), .rst(rst),
            .din({av_bus[i][j], a_bus[i][j]}), .dout(rq)
          );
          assign av_bus[i][j+1] = rq[DW];
          assign a_bus[i][j+1]  = rq[DW-1:0];
        end

        if (i < ROWS - 1) begin : g_down
          logic [CW-1:0] dq;
          sa_delay #(.W(CW), .DEPTH(1)) u_hop (
            .clk(clk), .rst(rst),
            .din({bv_bus[i][j], d_bus[i][j]}), .dout(dq)
          );
          assign bv_bus[i+1][j] = dq[CW-1];
          assign d_bus[i+1][j]  = dq[CW-2:0];
        end
      end
    end
  endgenerate

  // Completion: delay line of injections, pulse on the trailing edge
  logic [LAT-1:0] inj_sr;
  always_ff @(posedge clk) begin
    if (rst) begin
      inj_sr <= '0;
      done   <= 1'b0;
    end else begin
      inj_sr <= {inj_sr[LAT-2:0], a_valid & b_valid};
      done   <= inj_sr[LAT-1] & ~inj_sr[LAT-2];
    end
  end

  // Row readout, registered
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      for (int j = 0; j < COLS; j++) rd_data[j*AW +: AW] <= acc_g[rd_row][j];
    end
  end
endmodule

// File: rtl/sa_r16_array_chk.sv
module sa_r16_array_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 24,
  parameter int RW   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   a_valid,
  input logic                   b_valid,
  input logic [DW-1:0]          a0,
  input logic [DW-1:0]          b0,
  input logic [RW-1:0]          rd_row,
  input logic [COLS*AW-1:0]     rd_data,
  input logic                   done,
  input logic [ROWS*COLS*AW-1:0] acc_flat
);
  localparam int LAT = ROWS + COLS - 1;

  logic inj;
  assign inj = a_valid & b_valid;

  logic signed [2*DW-1:0] p00_n;
  logic [AW-1:0]          p00;
  assign p00_n = $signed(a0) * $signed(b0);
  assign p00   = {{(AW-2*DW){p00_n[2*DW-1]}}, p00_n};

  logic [AW-1:0] acc00;
  assign acc00 = acc_flat[AW-1:0];

  logic [COLS*AW-1:0] sel_row;
  always_comb begin
    sel_row = '0;
    for (int r = 0; r < ROWS; r++)
      if (RW'(r) == rd_row) sel_row = acc_flat[r*COLS*AW +: COLS*AW];
  end

  logic [5:0] idle_cnt;
  always_ff @(posedge clk) begin
    if (rst || inj) idle_cnt <= '0;
    else if (idle_cnt != 6'h3f) idle_cnt <= idle_cnt + 6'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (acc_flat == '0 && !done && rd_data == '0));

  assert_pe00_exact_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(inj, 2) && !$past(clr) && !$past(rst) && !$past(rst, 2))
      |-> acc00 == $past(acc00) + $past(p00, 2));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt > 6'(LAT) && !$past(clr) && !$past(rst)) |-> $stable(acc_flat));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !$past(rst)) |-> acc_flat == '0);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_readout_row_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data == $past(sel_row));
endmodule

bind sa_r16_array sa_r16_array_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW), .RW(RW)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .a_valid(a_valid), .b_valid(b_valid),
  .a0(a_data[DW-1:0]), .b0(b_data[DW-1:0]),
  .rd_row(rd_row), .rd_data(rd_data), .done(done),
  .acc_flat(acc_flat)
);

// File: tb/sa_r16_array_bench.sv
`timescale 1ns/1ps
module sa_r16_array_bench;
  localparam int ROWS = 4, COLS = 4, DW = 8, AW = 24, RW = 2;
  localparam int HD = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                clr = 1'b0;
  logic                a_valid = 1'b0, b_valid = 1'b0;
  logic [ROWS*DW-1:0]  a_data = '0;
  logic [COLS*DW-1:0]  b_data = '0;
  logic [RW-1:0]       rd_row = '0;
  logic [COLS*AW-1:0]  rd_data;
  logic                done;

  always #2 clk = ~clk;

  sa_r16_array u_sa_r16_array (
    .clk(clk), .rst(rst), .clr(clr),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .rd_row(rd_row), .rd_data(rd_data), .done(done)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // Behavioural reference: time-indexed history of injections
  logic          hinj [HD];
  logic [DW-1:0] ha [HD][ROWS];
  logic [DW-1:0] hb [HD][COLS];
  logic [AW-1:0] ref_acc [ROWS][COLS];
  logic [COLS*AW-1:0] exp_rd;
  logic          exp_done;
  int            exp_row;
  int            t = 0;
  bit            started = 0;

  initial begin
    for (int h = 0; h < HD; h++) hinj[h] = 1'b0;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) ref_acc[i][j] = '0;
  end

  always @(posedge clk) begin
    int idx;
    idx = t % HD;
    if (rst) begin
      for (int h = 0; h < HD; h++) hinj[h] = 1'b0;
    end else begin
      hinj[idx] = a_valid & b_valid;
      for (int i = 0; i < ROWS; i++) ha[idx][i] = a_data[i*DW +: DW];
      for (int j = 0; j < COLS; j++) hb[idx][j] = b_data[j*DW +: DW];
    end
    exp_row = int'(rd_row);
    for (int j = 0; j < COLS; j++)
      exp_rd[j*AW +: AW] = rst ? '0 : ref_acc[rd_row][j];
    exp_done = !rst && t >= 7 && hinj[(t-7) % HD] && !hinj[(t-6) % HD];
    for (int i = 0; i < ROWS; i++) begin
      for (int j = 0; j < COLS; j++) begin
        int s;
        s = t - 1 - i - j;
        if (rst || clr) ref_acc[i][j] = '0;
        else if (s >= 0 && hinj[s % HD]) begin
          int p;
          p = $signed(ha[s % HD][i]) * $signed(hb[s % HD][j]);
          ref_acc[i][j] = ref_acc[i][j] + p[AW-1:0];
        end
      end
    end
    t++;
    started = 1;
  end

  // Compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rd_data !== exp_rd) begin
        fails++;
        $display("FAIL %s rd_data row %0d actual %h expected %h", cur_req, exp_row, rd_data, exp_rd);
      end
      checks++;
      if (done !== exp_done) begin
        fails++;
        $display("FAIL R7 done actual %b expected %b at cycle %0d", done, exp_done, t);
      end
    end
    rd_row <= rd_row + 1'b1;
  end

  function automatic logic [7:0] corner(input int n);
    case (n % 5)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'hFF;
      3: return 8'h80;
      default: return 8'h7F;
    endcase
  endfunction

  task automatic step(input logic av, input logic bv, input logic cl,
                      input bit use_corner, input int k);
    a_valid = av; b_valid = bv; clr = cl;
    for (int i = 0; i < ROWS; i++)
      a_data[i*DW +: DW] = use_corner ? corner(k + i) : 8'($urandom);
    for (int j = 0; j < COLS; j++)
      b_data[j*DW +: DW] = use_corner ? corner(k + 2*j) : 8'($urandom);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step(1'b0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a17));
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);

    // R2: corner operands including -128 * -128
    cur_req = "R2";
    step(1'b0, 1'b0, 1'b1, 1'b0, 0);
    for (int k = 0; k < 15; k++) step(1'b1, 1'b1, 1'b0, 1'b1, k);
    idle(12);

    // R3: random matrices, clear coincident with the first injection
    cur_req = "R3";
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    for (int k = 1; k < 20; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 0);
    idle(12);

    // R4: valid flags driven independently
    cur_req = "R4";
    for (int k = 0; k < 24; k++)
      step(1'($urandom), 1'($urandom), 1'b0, 1'b0, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 0);
    idle(12);

    // R6: clear in the middle of a burst, terms in flight on the diagonals
    cur_req = "R6";
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, (k == 5) || (k == 9), 1'b0, 0);
    idle(4);
    step(1'b0, 1'b0, 1'b1, 1'b0, 0);
    idle(10);

    // R5 and R7: short bursts, gaps shorter and longer than the latency
    cur_req = "R5";
    step(1'b1, 1'b1, 1'b0, 1'b1, 3);
    idle(3);
    for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 0);
    idle(10);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 0);
    idle(1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8);
    idle(12);

    // R8: readout sweep of settled results
    cur_req = "R8";
    idle(8);
    finish_run();
  end
endmodule